// File: doc/BRIEF.md
# Clock-Generator Watchdog Timer

This block watches a clock generator for a system that stops responding. Software arms it by writing a 3-bit timeout count, and the count is measured in units of one of two base intervals. A short unit is roughly 294 ms and a long unit is roughly 2.34 s. Time advances only on a slow timebase tick supplied from outside. The block holds a parameter giving the number of ticks in each unit, so short test intervals are possible.

When the armed interval runs out, the block does three things. It sets a sticky alarm flag. It drives a system reset pulse of fixed length. Depending on a control bit, it may also strobe a request that tells the frequency synthesizer to return to a recovery setting. That setting is either the hardware strap value or a stored 9-bit divider, and the block presents the selected one on an output. A rewrite of the timer field with zero clears the alarm.

Top module: `clkgen_wdog`

## Requirements
- R1: After reset, `sys_rst_o`, `alarm_o` and `reload_o` are 0, the timer field is 000, and `rcv_div_o` shows `hw_div_i`.
- R2: The unit-select bit (`ctl_wdata_i[0]`, 1 = long unit of TICKS_LONG ticks, 0 = short unit of TICKS_SHORT ticks) leaves reset as 1.
- R3: With a timer value N from 1 to 7, the expiry happens on the N×unit-th tick counted after the write. The outputs change at the clock edge that samples that tick.
- R4: A timer value of 000 disables the watchdog, and no number of ticks causes an expiry.
- R5: `alarm_o` is set on expiry. It stays 1 through writes of nonzero timer values and through control writes. A timer write of 000 clears it.
- R6: With the action bit `ctl_wdata_i[1]` at 0, `reload_o` is a one-cycle strobe in the first cycle of the reset pulse. With the bit at 1, `reload_o` stays 0.
- R7: With the source bit `ctl_wdata_i[2]` at 1, `rcv_div_o` equals `sw_div_i`. With the bit at 0, it equals `hw_div_i`.
- R8: Each expiry drives `sys_rst_o` high for exactly RST_CYCLES clock cycles.
- R9: Any timer write restarts the count from zero.
- R10: After an expiry the count halts, and further ticks cause no new expiry until the timer is rewritten.
- R11: A timer write in the same cycle as the final tick takes precedence. No expiry occurs and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| tmr_we_i | input | 1 | Timer field write strobe |
| tmr_wdata_i | input | 3 | Timer count N to write |
| ctl_we_i | input | 1 | Control field write strobe |
| ctl_wdata_i | input | 3 | Bit 0 unit select, bit 1 reset-only, bit 2 recovery source |
| hw_div_i | input | 9 | Hardware strap recovery value |
| sw_div_i | input | 9 | Stored recovery divider |
| sys_rst_o | output | 1 | System reset pulse |
| alarm_o | output | 1 | Sticky expiry flag |
| reload_o | output | 1 | Recovery reload strobe |
| rcv_div_o | output | 9 | Selected recovery value |

## Verification
A wrong tick count or a wrong unit selection shows up at the first expiry. The reset pulse arrives one or more ticks early or late. The bench therefore checks the outputs one tick before the expected expiry and again on the expiring tick. A counter that fails to halt or to restart gives either a second reset pulse or a missing one within the next interval. A corrupted alarm or action bit is visible on `alarm_o` or `reload_o` in the same cycle the pulse starts.

// File: rtl/clkgen_wdog_pkg.sv
package clkgen_wdog_pkg;
  localparam int TMR_W = 3;
  localparam int DIV_W = 9;

  typedef struct packed {
    logic rcv_sw;
    logic rst_only;
    logic scale_long;
  } wdog_ctl_t;

  localparam wdog_ctl_t CTL_RST = '{rcv_sw: 1'b0, rst_only: 1'b0, scale_long: 1'b1};
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wdog_limit.sv
module wdog_limit #(
  parameter int TICKS_SHORT = 294,
  parameter int TICKS_LONG  = 2340,
  parameter int CNT_W       = 14
) (
  input  logic [2:0]       tmr_i,
  input  logic             scale_long_i,
  output logic [CNT_W-1:0] limit_o
);
  logic [CNT_W-1:0] unit;

  always_comb begin
    unit    = scale_long_i ? CNT_W'(TICKS_LONG) : CNT_W'(TICKS_SHORT);
    limit_o = CNT_W'(tmr_i) * unit;
  end
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc  = cnt_q + CNT_W'(1);
    cnt_d    = cnt_q;
    run_d    = run_q;
    expire_o = 1'b0;
    if (restart_i) begin
      cnt_d = '0;
      run_d = arm_i;
    end else if (run_q && tick_i) begin
      if (cnt_inc >= limit_i) begin
        expire_o = 1'b1;
        run_d    = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |-> !expire_o); // R11
endmodule

// File: rtl/wdog_act.sv
module wdog_act #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic rst_only_i,
  input  logic alarm_clr_i,
  output logic sys_rst_o,
  output logic reload_o,
  output logic alarm_o
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [RC_W-1:0] rc_q, rc_d;
  logic            rl_q, rl_d;
  logic            al_q, al_d;

  always_comb begin
    rc_d = rc_q;
    if (expire_i)          rc_d = RC_W'(RST_CYCLES);
    else if (rc_q != '0)   rc_d = rc_q - RC_W'(1);
    rl_d = expire_i && !rst_only_i;
    al_d = al_q;
    if (expire_i)          al_d = 1'b1;
    else if (alarm_clr_i)  al_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= '0;
      rl_q <= 1'b0;
      al_q <= 1'b0;
    end else begin
      rc_q <= rc_d;
      rl_q <= rl_d;
      al_q <= al_d;
    end
  end

  assign sys_rst_o = (rc_q != '0);
  assign reload_o  = rl_q;
  assign alarm_o   = al_q;

  AST_RELOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |=> !reload_o); // R6
  AST_RELOAD_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |-> sys_rst_o); // R6
  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !alarm_clr_i) |=> alarm_o); // R5
endmodule

// File: rtl/clkgen_wdog.sv
module clkgen_wdog
  import clkgen_wdog_pkg::*;
#(
  parameter int TICKS_SHORT = 294,
  parameter int TICKS_LONG  = 2340,
  parameter int RST_CYCLES  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             tmr_we_i,
  input  logic [TMR_W-1:0] tmr_wdata_i,
  input  logic             ctl_we_i,
  input  logic [2:0]       ctl_wdata_i,
  input  logic [DIV_W-1:0] hw_div_i,
  input  logic [DIV_W-1:0] sw_div_i,
  output logic             sys_rst_o,
  output logic             alarm_o,
  output logic             reload_o,
  output logic [DIV_W-1:0] rcv_div_o
);
  localparam int MAX_TICKS = 7 * TICKS_LONG;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             rst_s;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  wdog_ctl_t        ctl_q, ctl_d;
  logic [CNT_W-1:0] limit;
  logic             expire;
  logic             alarm_clr;

  wdog_rst_sync u_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  always_comb begin
    tmr_d = tmr_q;
    ctl_d = ctl_q;
    if (tmr_we_i) tmr_d = tmr_wdata_i;
    if (ctl_we_i) ctl_d = wdog_ctl_t'(ctl_wdata_i);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      tmr_q <= '0;
      ctl_q <= CTL_RST;
    end else begin
      tmr_q <= tmr_d;
      ctl_q <= ctl_d;
    end
  end

  assign alarm_clr = tmr_we_i && (tmr_wdata_i == '0);

  wdog_limit #(.TICKS_SHORT(TICKS_SHORT), .TICKS_LONG(TICKS_LONG), .CNT_W(CNT_W)) u_lim (
    .tmr_i(tmr_q), .scale_long_i(ctl_q.scale_long), .limit_o(limit));

  wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .tick_i(tick_i), .restart_i(tmr_we_i),
    .arm_i(tmr_wdata_i != '0), .limit_i(limit), .expire_o(expire));

  wdog_act #(.RST_CYCLES(RST_CYCLES)) u_act (
    .clk(clk), .rst_n(rst_s), .expire_i(expire), .rst_only_i(ctl_q.rst_only),
    .alarm_clr_i(alarm_clr), .sys_rst_o(sys_rst_o), .reload_o(reload_o),
    .alarm_o(alarm_o));

  assign rcv_div_o = ctl_q.rcv_sw ? sw_div_i : hw_div_i;

  AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_s)
    (tmr_q == '0) |-> !expire); // R4
  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    expire |=> (sys_rst_o && alarm_o)); // R8
endmodule

// File: tb/sim_clkgen_wdog.sv
module sim_clkgen_wdog;
  localparam int CLK_PER = 10;
  localparam int TS      = 3;
  localparam int TL      = 24;
  localparam int RC      = 4;
  localparam logic [8:0] HW = 9'h0A5;
  localparam logic [8:0] SW = 9'h15A;
  localparam int NV = 6;
  // [13] long unit, [12:10] N, [9] reset-only, [8] sw source, [7:0] ticks to expiry
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 3'd1, 1'b0, 1'b0, 8'd3},
    {1'b0, 3'd7, 1'b1, 1'b1, 8'd21},
    {1'b1, 3'd1, 1'b0, 1'b1, 8'd24},
    {1'b1, 3'd3, 1'b1, 1'b0, 8'd72},
    {1'b0, 3'd5, 1'b0, 1'b0, 8'd15},
    {1'b1, 3'd7, 1'b0, 1'b1, 8'd168}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic tmr_we = 1'b0, ctl_we = 1'b0;
  logic [2:0] tmr_wd = '0, ctl_wd = '0;
  logic sys_rst, alarm, reload;
  logic [8:0] rcv_div;
  int total = 0, bad = 0, cyc = 0, rst_cycles = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  clkgen_wdog #(.TICKS_SHORT(TS), .TICKS_LONG(TL), .RST_CYCLES(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .tmr_we_i(tmr_we), .tmr_wdata_i(tmr_wd),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd), .hw_div_i(HW), .sw_div_i(SW),
    .sys_rst_o(sys_rst), .alarm_o(alarm), .reload_o(reload), .rcv_div_o(rcv_div));

  always @(negedge clk) if (sys_rst) rst_cycles++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr_tmr(input logic [2:0] v);
    tmr_we = 1'b1; tmr_wd = v;
    @(negedge clk);
    tmr_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    ctl_we = 1'b1; ctl_wd = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic one_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_width(output int w);
    w = 1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (sys_rst) w++;
      else break;
    end
  endtask

  initial begin
    int w, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sys_rst", sys_rst, 0);
    chk("R1 alarm", alarm, 0);
    chk("R1 reload", reload, 0);
    chk("R1 rcv_div", rcv_div, HW);
    // R2 unit bit defaults to long: N=1 expires on tick TL
    wr_tmr(3'd1);
    ticks(TL - 1);
    chk("R2 early", sys_rst, 0);
    one_tick();
    chk("R2 fire", sys_rst, 1);
    chk("R6 default reload", reload, 1);
    pulse_width(w);
    chk("R8 width", w, RC);
    // R10 halted after expiry
    base = rst_cycles;
    ticks(3 * TL);
    chk("R10 no refire", rst_cycles - base, 0);
    // R5 sticky alarm
    wr_tmr(3'd4);
    chk("R5 hold on nonzero write", alarm, 1);
    wr_ctl(3'b001);
    chk("R5 hold on ctl write", alarm, 1);
    wr_tmr(3'd0);
    chk("R5 clear", alarm, 0);
    // R4 disabled with 000
    base = rst_cycles;
    ticks(8 * TL);
    chk("R4 no fire", rst_cycles - base, 0);
    chk("R4 alarm", alarm, 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      logic [13:0] e;
      e = VEC[v];
      wr_tmr(3'd0);
      chk("R5 cleared", alarm, 0);
      wr_ctl({e[8], e[9], e[13]});
      chk("R7 source", rcv_div, e[8] ? SW : HW);
      wr_tmr(e[12:10]);
      ticks(int'(e[7:0]) - 1);
      chk("R3 one early", sys_rst, 0);
      one_tick();
      chk("R3 fire", sys_rst, 1);
      chk("R5 set", alarm, 1);
      chk("R6 reload", reload, e[9] ? 0 : 1);
      chk("R7 value", rcv_div, e[8] ? SW : HW);
      pulse_width(w);
      chk("R8 width", w, RC);
      chk("R6 strobe ended", reload, 0);
    end

    // R9 restart on write (short unit, N=2 => 6 ticks)
    wr_tmr(3'd0);
    wr_ctl(3'b000);
    wr_tmr(3'd2);
    ticks(4);
    wr_tmr(3'd2);
    base = rst_cycles;
    ticks(5);
    chk("R9 restarted", rst_cycles - base, 0);
    one_tick();
    chk("R9 fire", sys_rst, 1);
    pulse_width(w);

    // R11 write on final tick wins (N=1 short => 3 ticks)
    wr_tmr(3'd0);
    wr_tmr(3'd1);
    ticks(2);
    tick = 1'b1; tmr_we = 1'b1; tmr_wd = 3'd1;
    @(negedge clk);
    tick = 1'b0; tmr_we = 1'b0;
    chk("R11 no fire", sys_rst, 0);
    chk("R11 alarm", alarm, 0);
    ticks(2);
    chk("R11 still counting", sys_rst, 0);
    one_tick();
    chk("R11 fire after restart", sys_rst, 1);
    pulse_width(w);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule